// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus. It takes one operation request at a time and turns it into the bus cycles the flash expects: command bytes with CLE high, address bytes with ALE high, and data bytes with both low. Every written byte is framed by chip enable and a write-strobe pulse. Read bytes are framed by a read-strobe pulse. Once the confirm byte has gone out, the block waits on the ready/busy line. It then moves page data through a byte stream that uses valid/ready handshakes.

The request carries an operation code, a 12-bit column, a 19-bit row and a byte count. The codes are 0 page read, 1 page program, 2 block erase, 3 status read, 4 ID read, 5 reset and 6 random output inside the loaded page. After a program or an erase, the block fetches the status byte by itself and reports bit 0 of it as the result. Each strobe phase lasts a parameterised number of clocks. A busy phase that runs too long ends the operation with a timeout flag.

Top module: `nand_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high, CLE, ALE, op_done and rd_valid are low, and op_ready is high.
- R2: Chip enable is low for the whole of an operation. A byte is latched on the rising write strobe. Command bytes carry CLE=1 and ALE=0, address bytes carry ALE=1 and CLE=0, and data bytes carry both at 0. The output byte, CLE and ALE stay stable while the write strobe is low.
- R3: Operation code 0 (read) sends 00h, then five address bytes, then 30h, and waits for ready. The five address bytes are col[7:0], col[11:8], row[7:0], row[15:8] and row[18:16]. It then delivers op_len bytes on rd_data, and holds each byte while rd_valid is high and rd_ready is low.
- R4: Operation code 1 (program) sends 80h and the five address bytes of R3. It then sends op_len data bytes taken from the write stream, then 10h. It waits for ready and sends 70h, and op_fail reflects bit 0 of the status byte read back.
- R5: Operation code 2 (erase) sends 60h, then only row[7:0], row[15:8] and row[18:16], then D0h. It waits for ready and finishes with the automatic 70h status check of R4.
- R6: Operation code 3 sends 70h and delivers one status byte. Code 4 sends 90h and one address byte 00h, then delivers op_len bytes. Code 5 sends FFh and waits for ready.
- R7: Operation code 6 (random output) sends 05h, col[7:0], col[11:8] and E0h, then delivers op_len bytes without a busy wait.
- R8: Every write-strobe low phase lasts exactly WL clocks, and every read-strobe low phase lasts exactly RL clocks.
- R9: After a confirm byte the block waits WB clocks and then until rb_n is high. It never lowers the read strobe while rb_n is low.
- R10: If a busy wait lasts TMO clocks, the operation ends with op_done, op_fail=1 and op_timeout=1.
- R11: A request is taken only when op_ready is high. op_valid during an operation has no effect on the bus.
- R12: op_done is a one-cycle pulse after which op_ready is high again. op_fail is cleared when a request is taken and stays 0 for operations without a status check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Block idle, request accepted |
| op_code | input | 3 | Operation code (0..6) |
| op_col | input | COL_W | Column address |
| op_row | input | ROW_W | Row (page) address |
| op_len | input | LEN_W | Data byte count (0 treated as 1) |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Program data taken this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Read data accepted |
| op_done | output | 1 | Operation finished pulse |
| op_fail | output | 1 | Status bit 0 or timeout |
| op_timeout | output | 1 | Busy wait timed out |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus byte driven by the block |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus byte from the flash |
| nand_rb_n | input | 1 | Ready/busy, low when busy |

## Verification
The assertions check four things on every cycle. The bus byte and the latch enables must hold steady under a low write strobe. A held read byte must not change under backpressure. No read strobe may fall while the flash is busy. The done pulse and the timeout result must keep their shape. Only the bench scenarios can show that each operation code produces the right ordered byte sequence with the right address slicing, that streamed data and status results are correct, that strobe widths match the parameters, and that a request made mid-operation leaves the bus untouched.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int WL    = 2,
  parameter int WH    = 2,
  parameter int RL    = 2,
  parameter int RH    = 2,
  parameter int WB    = 4,
  parameter int TMO   = 4096,
  parameter int COL_W = 12,
  parameter int ROW_W = 19,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_code,
  input  logic [COL_W-1:0] op_col,
  input  logic [ROW_W-1:0] op_row,
  input  logic [LEN_W-1:0] op_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             op_done,
  output logic             op_fail,
  output logic             op_timeout,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_n
);
  localparam int PM1 = (WL > WH) ? WL : WH;
  localparam int PM2 = (RL > RH) ? RL : RH;
  localparam int PM3 = (PM1 > PM2) ? PM1 : PM2;
  localparam int PMX = (PM3 > WB) ? PM3 : WB;
  localparam int CW  = $clog2(PMX + 1);
  localparam int TW  = $clog2(TMO + 1);

  localparam logic [2:0] OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2,
                         OP_STAT = 3'd3, OP_ID = 3'd4, OP_RST = 3'd5, OP_RAND = 3'd6;
  localparam logic [2:0] K_CMD = 3'd0, K_ADR = 3'd1, K_WR = 3'd2, K_RD = 3'd3,
                         K_RS = 3'd4, K_WT = 3'd5, K_END = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_WLO, S_WHI, S_RLO, S_RHI, S_HOLD, S_WAIT} st_t;
  st_t st;
  logic             fin;
  logic [2:0]       op_q, cur_k;
  logic [7:0]       cur_b, cap;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [LEN_W-1:0] rem;
  logic [3:0]       idx;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    tmo;
  logic             fail_q, tmo_q;
  logic [10:0]      item;
  logic [15:0]      col16;
  logic [23:0]      row24;
  logic [7:0]       ab [0:5];

  assign col16 = 16'(col_q);
  assign row24 = 24'(row_q);
  assign ab[0] = col16[7:0];
  assign ab[1] = col16[15:8];
  assign ab[2] = row24[7:0];
  assign ab[3] = row24[15:8];
  assign ab[4] = row24[23:16];
  assign ab[5] = 8'h00;

  always_comb begin
    item = {K_END, 8'h00};
    case (op_q)
      OP_READ: case (idx)
        4'd0: item = {K_CMD, 8'h00};
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5: item = {K_ADR, ab[3'(idx - 4'd1)]};
        4'd6: item = {K_CMD, 8'h30};
        4'd7: item = {K_WT, 8'h00};
        4'd8: item = {K_RD, 8'h00};
        default: ;
      endcase
      OP_PROG: case (idx)
        4'd0: item = {K_CMD, 8'h80};
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5: item = {K_ADR, ab[3'(idx - 4'd1)]};
        4'd6: item = {K_WR, 8'h00};
        4'd7: item = {K_CMD, 8'h10};
        4'd8: item = {K_WT, 8'h00};
        4'd9: item = {K_CMD, 8'h70};
        4'd10: item = {K_RS, 8'h00};
        default: ;
      endcase
      OP_ERASE: case (idx)
        4'd0: item = {K_CMD, 8'h60};
        4'd1, 4'd2, 4'd3: item = {K_ADR, ab[3'(idx + 4'd1)]};
        4'd4: item = {K_CMD, 8'hD0};
        4'd5: item = {K_WT, 8'h00};
        4'd6: item = {K_CMD, 8'h70};
        4'd7: item = {K_RS, 8'h00};
        default: ;
      endcase
      OP_STAT: case (idx)
        4'd0: item = {K_CMD, 8'h70};
        4'd1: item = {K_RD, 8'h00};
        default: ;
      endcase
      OP_ID: case (idx)
        4'd0: item = {K_CMD, 8'h90};
        4'd1: item = {K_ADR, ab[5]};
        4'd2: item = {K_RD, 8'h00};
        default: ;
      endcase
      OP_RST: case (idx)
        4'd0: item = {K_CMD, 8'hFF};
        4'd1: item = {K_WT, 8'h00};
        default: ;
      endcase
      OP_RAND: case (idx)
        4'd0: item = {K_CMD, 8'h05};
        4'd1, 4'd2: item = {K_ADR, ab[3'(idx - 4'd1)]};
        4'd3: item = {K_CMD, 8'hE0};
        4'd4: item = {K_RD, 8'h00};
        default: ;
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fin <= 1'b0; op_q <= '0; cur_k <= K_END; cur_b <= '0; cap <= '0;
      col_q <= '0; row_q <= '0; rem <= '0; idx <= '0; cnt <= '0; tmo <= '0;
      fail_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        S_IDLE: if (op_valid && !fin) begin
          op_q <= op_code; col_q <= op_col; row_q <= op_row; idx <= '0;
          rem <= (op_len == '0 || op_code == OP_STAT) ? LEN_W'(1) : op_len;
          fail_q <= 1'b0; tmo_q <= 1'b0; st <= S_STEP;
        end
        S_STEP: begin
          cur_k <= item[10:8];
          case (item[10:8])
            K_CMD, K_ADR: begin cur_b <= item[7:0]; cnt <= CW'(WL - 1); st <= S_WLO; end
            K_WR: if (wr_valid) begin cur_b <= wr_data; cnt <= CW'(WL - 1); st <= S_WLO; end
            K_RD, K_RS: begin cnt <= CW'(RL - 1); st <= S_RLO; end
            K_WT: begin cnt <= CW'(WB - 1); tmo <= '0; st <= S_WAIT; end
            default: begin fin <= 1'b1; st <= S_IDLE; end
          endcase
        end
        S_WLO: if (cnt == '0) begin cnt <= CW'(WH - 1); st <= S_WHI; end else cnt <= cnt - CW'(1);
        S_WHI: if (cnt == '0) begin
          st <= S_STEP;
          if (cur_k == K_WR && rem != LEN_W'(1)) rem <= rem - LEN_W'(1); else idx <= idx + 4'd1;
        end else cnt <= cnt - CW'(1);
        S_RLO: if (cnt == '0) begin cap <= nand_dq_i; cnt <= CW'(RH - 1); st <= S_RHI; end
               else cnt <= cnt - CW'(1);
        S_RHI: if (cnt == '0) begin
          if (cur_k == K_RS) begin fail_q <= cap[0]; idx <= idx + 4'd1; st <= S_STEP; end
          else st <= S_HOLD;
        end else cnt <= cnt - CW'(1);
        S_HOLD: if (rd_ready) begin
          st <= S_STEP;
          if (rem != LEN_W'(1)) rem <= rem - LEN_W'(1); else idx <= idx + 4'd1;
        end
        S_WAIT: begin
          tmo <= tmo + TW'(1);
          if (tmo == TW'(TMO - 1)) begin tmo_q <= 1'b1; fail_q <= 1'b1; fin <= 1'b1; st <= S_IDLE; end
          else if (cnt != '0) cnt <= cnt - CW'(1);
          else if (nand_rb_n) begin idx <= idx + 4'd1; st <= S_STEP; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic wr_cyc;
  assign wr_cyc     = (st == S_WLO) || (st == S_WHI);
  assign op_ready   = (st == S_IDLE) && !fin;
  assign op_done    = fin;
  assign op_fail    = fail_q;
  assign op_timeout = tmo_q;
  assign wr_ready   = (st == S_STEP) && (item[10:8] == K_WR);
  assign rd_valid   = (st == S_HOLD);
  assign rd_data    = cap;
  assign nand_ce_n  = (st == S_IDLE);
  assign nand_we_n  = (st != S_WLO);
  assign nand_re_n  = (st != S_RLO);
  assign nand_cle   = wr_cyc && (cur_k == K_CMD);
  assign nand_ale   = wr_cyc && (cur_k == K_ADR);
  assign nand_dq_oe = wr_cyc;
  assign nand_dq_o  = cur_b;

  AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale))); // R2
  AST_STROBE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R3
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> nand_rb_n); // R9
  AST_TMO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    op_timeout |-> op_fail); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (!op_done && op_ready)); // R12
endmodule

// File: tb/test_nand_seq.sv
module test_nand_seq;
  localparam int CLK_P = 10;
  localparam int WL = 3, WH = 2, RL = 2, RH = 1, WB = 3, TMO = 200;
  localparam int NV = 10;
  // fields: op[63:60] col[59:48] row[47:28] len[27:16] busy[15:8] stat[7:0]
  localparam logic [63:0] VEC [NV] = '{
    {4'd0, 12'h835, 20'h5A3C7, 12'd3, 8'd12, 8'hE0},
    {4'd0, 12'h000, 20'h7FFFF, 12'd1, 8'd40, 8'hE0},
    {4'd1, 12'h010, 20'h12345, 12'd4, 8'd15, 8'hE0},
    {4'd1, 12'h83F, 20'h00001, 12'd2, 8'd8,  8'hE1},
    {4'd2, 12'h000, 20'h4ABCD, 12'd1, 8'd20, 8'hE0},
    {4'd2, 12'h000, 20'h00040, 12'd1, 8'd10, 8'hC1},
    {4'd3, 12'h000, 20'h00000, 12'd5, 8'd5,  8'hA5},
    {4'd4, 12'h000, 20'h00000, 12'd5, 8'd5,  8'hE0},
    {4'd5, 12'h000, 20'h00000, 12'd1, 8'd25, 8'hE0},
    {4'd6, 12'h7FE, 20'h00000, 12'd4, 8'd5,  8'hE0}
  };

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, wr_valid = 1, rd_ready = 1;
  logic [2:0] op_code = 0;
  logic [11:0] op_col = 0, op_len = 0;
  logic [18:0] op_row = 0;
  logic [7:0] wr_data, rd_data, dq_o, dq_i;
  logic op_ready, wr_ready, rd_valid, op_done, op_fail, op_timeout;
  logic ce_n, cle, ale, we_n, re_n, dq_oe;
  logic rb_n = 1;

  nand_seq #(.WL(WL), .WH(WH), .RL(RL), .RH(RH), .WB(WB), .TMO(TMO)) i_nand_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_col(op_col), .op_row(op_row), .op_len(op_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .op_done(op_done), .op_fail(op_fail), .op_timeout(op_timeout), .nand_ce_n(ce_n),
    .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_o(dq_o),
    .nand_dq_oe(dq_oe), .nand_dq_i(dq_i), .nand_rb_n(rb_n));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  int busy_len = 5, bcnt = 0, rdcnt = 0, log_n = 0, rx_n = 0, wr_k = 0;
  int we_run = 0, re_run = 0, bad_w = 0, bad_r = 0, viol = 0;
  bit stuck = 0, mode_st = 0, exp_col = 0, take = 0;
  logic pwe = 1, pre = 1;
  logic [7:0] stat_v = 8'hE0, col_lo = 0;
  logic [9:0] log_m [512];
  logic [7:0] rx [512];

  assign dq_i    = mode_st ? stat_v : col_lo + 8'(rdcnt);
  assign wr_data = 8'h50 + 8'(wr_k);

  // flash model and monitors
  always @(negedge clk) begin
    if (take) wr_k++;
    take = wr_valid && wr_ready;
    if (!we_n) we_run++;
    if (we_n && !pwe) begin
      if (we_run != WL) bad_w++;
      we_run = 0;
      log_m[log_n % 512] = {cle, ale, dq_o};
      log_n++;
      if (cle) begin
        mode_st = (dq_o == 8'h70); exp_col = 1; rdcnt = 0;
        if (dq_o == 8'h30 || dq_o == 8'h10 || dq_o == 8'hD0 || dq_o == 8'hFF) begin
          rb_n = 0; bcnt = busy_len;
        end
      end else if (ale && exp_col) begin col_lo = dq_o; exp_col = 0; end
    end else if (!rb_n && !stuck) begin
      if (bcnt == 0) rb_n = 1; else bcnt--;
    end
    if (!re_n) begin re_run++; if (!rb_n) viol++; end
    if (re_n && !pre) begin if (re_run != RL) bad_r++; re_run = 0; rdcnt++; end
    if (rd_valid && rd_ready) begin rx[rx_n % 512] = rd_data; rx_n++; end
    pwe = we_n; pre = re_n;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string rq(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      6: return "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic int exp_n(input int op, input int len);
    case (op)
      0: return 7;
      1: return 8 + len;
      2: return 6;
      4: return 2;
      6: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [9:0] exp_item(input int op, input logic [11:0] col, input logic [18:0] row,
                                          input int len, input int wb, input int i);
    logic [7:0] a [5];
    a[0] = col[7:0]; a[1] = {4'h0, col[11:8]}; a[2] = row[7:0]; a[3] = row[15:8]; a[4] = {5'h0, row[18:16]};
    case (op)
      0: return (i == 0) ? {2'b10, 8'h00} : (i < 6) ? {2'b01, a[i-1]} : {2'b10, 8'h30};
      1: if (i == 0) return {2'b10, 8'h80};
         else if (i < 6) return {2'b01, a[i-1]};
         else if (i < 6 + len) return {2'b00, 8'h50 + 8'(wb + i - 6)};
         else if (i == 6 + len) return {2'b10, 8'h10};
         else return {2'b10, 8'h70};
      2: return (i == 0) ? {2'b10, 8'h60} : (i < 4) ? {2'b01, a[i+1]} : (i == 4) ? {2'b10, 8'hD0} : {2'b10, 8'h70};
      3: return {2'b10, 8'h70};
      4: return (i == 0) ? {2'b10, 8'h90} : {2'b01, 8'h00};
      5: return {2'b10, 8'hFF};
      default: return (i == 0) ? {2'b10, 8'h05} : (i < 3) ? {2'b01, a[i-1]} : {2'b10, 8'hE0};
    endcase
  endfunction

  task automatic start_op(input int op, input logic [11:0] col, input logic [18:0] row,
                          input int len, input int busy, input logic [7:0] st);
    @(negedge clk);
    busy_len = busy; stat_v = st;
    op_code = 3'(op); op_col = col; op_row = row; op_len = 12'(len); op_valid = 1;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic wait_done(output bit f, output bit t);
    int c = 0;
    while (!op_done && c < 3000) begin @(negedge clk); c++; end
    f = op_fail; t = op_timeout;
    chk(op_done, "R12", "op_done seen", int'(op_done), 1);
  endtask

  initial begin
    bit f, t;
    int lb, rb, wb, mism, en, ef, op, len;
    logic [11:0] col;
    logic [18:0] row;
    logic [7:0] st, ev;
    #(CLK_P*3);
    // R1: reset state
    chk({ce_n, we_n, re_n, cle, ale, op_ready, op_done, rd_valid} == 8'b11100100, "R1", "idle outputs",
        {ce_n, we_n, re_n, cle, ale, op_ready, op_done, rd_valid}, 8'b11100100);
    rst_n = 1;
    @(negedge clk);
    chk(op_ready && ce_n, "R1", "ready after reset", op_ready, 1);

    for (int v = 0; v < NV; v++) begin
      op = int'(VEC[v][63:60]); col = VEC[v][59:48]; row = VEC[v][46:28];
      len = int'(VEC[v][27:16]); st = VEC[v][7:0];
      lb = log_n; rb = rx_n; wb = wr_k;
      start_op(op, col, row, len, int'(VEC[v][15:8]), st);
      wait_done(f, t);
      mism = 0;
      for (int i = 0; i < exp_n(op, len) && i < log_n - lb; i++)
        if (log_m[(lb + i) % 512] != exp_item(op, col, row, len, wb, i)) mism++;
      chk(log_n - lb == exp_n(op, len) && mism == 0, {rq(op), "/R2"}, "bus byte sequence",
          (log_n - lb) * 256 + mism, exp_n(op, len) * 256);
      en = (op == 0 || op == 4 || op == 6) ? len : (op == 3) ? 1 : 0;
      mism = 0;
      for (int k = 0; k < en && k < rx_n - rb; k++) begin
        ev = (op == 3) ? st : (op == 4) ? 8'(k) : col[7:0] + 8'(k);
        if (rx[(rb + k) % 512] != ev) mism++;
      end
      chk(rx_n - rb == en && mism == 0, rq(op), "read stream", (rx_n - rb) * 256 + mism, en * 256);
      ef = (op == 1 || op == 2) ? int'(st[0]) : 0;
      chk(f == ef[0] && !t, (op == 1 || op == 2) ? rq(op) : "R12", "op_fail result", int'(f), ef);
      @(negedge clk);
    end
    chk(bad_w == 0 && bad_r == 0, "R8", "strobe low widths", bad_w * 256 + bad_r, 0);
    chk(viol == 0, "R9", "read strobe while busy", viol, 0);

    // R10: busy never ends
    stuck = 1; lb = log_n;
    start_op(2, 12'h0, 19'h00123, 1, 5, 8'hE0);
    wait_done(f, t);
    chk(f && t, "R10", "timeout result", {f, t}, 2'b11);
    chk(log_n - lb == 5, "R10", "no status after timeout", log_n - lb, 5);
    stuck = 0;
    repeat (10) @(negedge clk);
    start_op(5, 12'h0, 19'h0, 1, 6, 8'hE0);
    wait_done(f, t);
    chk(!f && !t, "R12", "flags clear on next op", {f, t}, 0);

    // R11: request during an operation is ignored
    lb = log_n; rb = rx_n; mism = 0;
    start_op(0, 12'h020, 19'h00100, 2, 60, 8'hE0);
    repeat (15) @(negedge clk);
    op_code = 3'd5; op_valid = 1;
    for (int k = 0; k < 5; k++) begin @(negedge clk); if (op_ready) mism++; end
    op_valid = 0;
    chk(mism == 0, "R11", "op_ready low while busy", mism, 0);
    wait_done(f, t);
    mism = 0;
    for (int i = 0; i < 7 && i < log_n - lb; i++)
      if (log_m[(lb + i) % 512] != exp_item(0, 12'h020, 19'h00100, 2, 0, i)) mism++;
    chk(log_n - lb == 7 && mism == 0, "R11", "bus unchanged by extra request", (log_n - lb) * 256 + mism, 7 * 256);
    chk(rx_n - rb == 2 && rx[rb % 512] == 8'h20 && rx[(rb + 1) % 512] == 8'h21, "R3", "data after long busy",
        rx_n - rb, 2);
    @(negedge clk);
    chk(!op_done && op_ready, "R12", "done is a single pulse", {op_done, op_ready}, 1);

    // R3: backpressure on read stream
    rb = rx_n;
    start_op(6, 12'h040, 19'h0, 2, 5, 8'hE0);
    rd_ready = 0;
    repeat (30) @(negedge clk);
    chk(rd_valid && rd_data == 8'h40, "R3", "byte held under backpressure", rd_data, 8'h40);
    rd_ready = 1;
    wait_done(f, t);
    chk(rx_n - rb == 2 && rx[(rb + 1) % 512] == 8'h41, "R7", "stream resumes", rx_n - rb, 2);
    chk(viol == 0 && bad_w == 0 && bad_r == 0, "R9", "strobe rules over all ops", viol + bad_w + bad_r, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule